// File: doc/BRIEF.md
# Serial NAND bring-up sequencer

This block brings a serial NAND device to a usable state after power-up. A single start pulse launches a fixed chain of commands through a command engine that drives one chip select. The chain reads the identification bytes, forms a 16-bit device ID and looks it up in a small built-in parameter table. It then removes the block-lock protection. On devices that can run four data lanes, it switches the device into quad mode with a read-modify-write of a configuration register. The SPI shifter itself sits behind a request/response handshake and is not part of this block.

When the chain ends, the block gives the page-read and page-program opcodes, the lane mode for each, and the array geometry of the matched device. A one-cycle done pulse carries a 2-bit result. Any trouble while quad mode is being set up is not fatal. The block stays on one lane and still reports success.

Top module: `nand_bringup_seq`

## Requirements
- R1: After reset: `busy_o`=0, `done_o`=0 and `cmd_valid_o`=0. The page-read opcode is 0x03 and the page-program opcode is 0x02, with `rd_quad_o`=0 and `pg_quad_o`=0.
- R2: A `start_i` pulse while idle issues the first command: opcode 0x9F with one address byte 0x00, no data byte, and `cmd_rd_len_o`=3. A command is held with stable fields while `cmd_ready_i` is low. A `start_i` pulse while busy is ignored.
- R3: Response bytes arrive in `rsp_rdata_i`, with the last byte received in bits [7:0]. An identification byte 0 (bits [23:16]) of 0xFF or 0x00 ends the run with result 1 (no device), after that single command.
- R4: The ID is {byte 0, byte 1}, taken from bits [23:8]. An ID absent from the table ends the run with result 2 (unsupported). The table holds 0xC8F1, 0xEFAA, 0x98C2 and 0x2C24.
- R5: A supported ID is followed by a write-enable (opcode 0x06, no address, no data, no read bytes). Then comes a register write: opcode 0x1F, address 0xA0, data byte 0x00. `cmd_wr_en_o` is high only for opcode 0x1F.
- R6: A response with `rsp_err_i` set, to any of the first three commands, ends the run with result 3 (bus error) and no further command.
- R7: Some table entries are quad capable with a real bit index: 0xC8F1 (register 0xB0, bit 0) and 0x2C24 (register 0xB0, bit 3). For these, the block reads that register (opcode 0x0F, 1 read byte). If the bit is already set, no write follows. Otherwise a write-enable comes first, then opcode 0x1F to the same address with the old value ORed with the bit.
- R8: 0xEFAA is quad capable with bit index 0xFF. It finishes after the lock clear with quad mode selected and no configuration-register access.
- R9: Quad read selects read opcode 0x6B with `rd_quad_o`=1. Quad program (0x32, `pg_quad_o`=1) is selected only when quad read was enabled and the entry allows it. 0x2C24 allows quad read only. 0x98C2 has no quad mode and keeps 0x03/0x02 on one lane.
- R10: An error response during the quad set-up (register read, its write-enable or its write) ends the run with result 0 and one-lane opcodes.
- R11: Geometry outputs come from the matched entry. 0xC8F1, 0xEFAA and 0x98C2 have 4 sectors per page, 64 pages per block, 1 plane and 1024 blocks per plane. 0x2C24 has 8 sectors per page, 128 pages per block, 2 planes and 2048 blocks per plane.
- R12: `busy_o` is high from the cycle after an accepted start until the cycle of `done_o`. `done_o` is a one-cycle pulse. `result_o` holds its code (0 ok, 1 no device, 2 unsupported, 3 bus error) until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the bring-up chain |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Outcome code |
| cmd_valid_o | output | 1 | Command request valid |
| cmd_ready_i | input | 1 | Engine accepts the command |
| cmd_opcode_o | output | 8 | Command opcode |
| cmd_addr_en_o | output | 1 | One address byte follows the opcode |
| cmd_addr_o | output | 8 | Address byte |
| cmd_wr_en_o | output | 1 | One data byte is sent |
| cmd_wdata_o | output | 8 | Data byte to send |
| cmd_rd_len_o | output | 2 | Bytes to read back |
| rsp_valid_i | input | 1 | Command finished |
| rsp_err_i | input | 1 | Command failed on the bus |
| rsp_rdata_i | input | 24 | Bytes read, last byte in [7:0] |
| rd_opcode_o | output | 8 | Selected page-read opcode |
| pg_opcode_o | output | 8 | Selected program-load opcode |
| rd_quad_o | output | 1 | Page read uses four lanes |
| pg_quad_o | output | 1 | Program load uses four lanes |
| sec_per_page_o | output | 4 | Sectors per page |
| pg_per_blk_o | output | 8 | Pages per block |
| planes_o | output | 2 | Planes per die |
| blk_per_plane_o | output | 12 | Blocks per plane |

## Verification
A wrong step in the sequencer shows up at the command port at once, as an extra, missing or reordered command. It also shows in the device-side register values the bench model holds at the end of the run. A wrongly latched quad decision or table entry shows only at done, in the opcodes, lane flags and geometry. Each run is therefore checked both by its command count and the final register contents, and by every configuration output in the cycles after the pulse. Error injection at each command index shows whether a failure is fatal (first three commands) or degrades to one lane (quad set-up).

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    localparam int DEV_CNT = 4;
    localparam int BYTE_W  = 8;
    localparam int ID_W    = 2 * BYTE_W;
    localparam int RSP_W   = 3 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_READ_ID = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_WREN    = 8'h06;
    localparam logic [BYTE_W-1:0] OP_REG_RD  = 8'h0F;
    localparam logic [BYTE_W-1:0] OP_REG_WR  = 8'h1F;
    localparam logic [BYTE_W-1:0] OP_RD_X1   = 8'h03;
    localparam logic [BYTE_W-1:0] OP_PG_X1   = 8'h02;
    localparam logic [BYTE_W-1:0] OP_RD_X4   = 8'h6B;
    localparam logic [BYTE_W-1:0] OP_PG_X4   = 8'h32;
    localparam logic [BYTE_W-1:0] REG_LOCK   = 8'hA0;
    localparam logic [BYTE_W-1:0] LOCK_OPEN  = 8'h00;
    localparam logic [BYTE_W-1:0] QE_NONE    = 8'hFF;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_NODEV  = 2'd1,
        RES_UNSUP  = 2'd2,
        RES_BUSERR = 2'd3
    } result_e;

    typedef enum logic [2:0] {
        STEP_ID, STEP_WEN_LOCK, STEP_LOCK, STEP_QE_RD, STEP_WEN_QE, STEP_QE_WR
    } step_e;

    typedef struct packed {
        logic              quad_rd;
        logic              quad_pg;
        logic [BYTE_W-1:0] qe_addr;
        logic [BYTE_W-1:0] qe_bit;
    } qe_info_t;

    typedef struct packed {
        logic [3:0]  sec_per_page;
        logic [7:0]  pg_per_blk;
        logic [1:0]  planes;
        logic [11:0] blk_per_plane;
    } geo_t;

    typedef struct packed {
        qe_info_t qe;
        geo_t     geo;
    } dev_cfg_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        dev_cfg_t        cfg;
    } dev_rom_t;

    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic              addr_en;
        logic [BYTE_W-1:0] addr;
        logic              wr_en;
        logic [BYTE_W-1:0] wdata;
        logic [1:0]        rd_len;
    } cmd_t;

    function automatic dev_rom_t dev_rom(input int idx);
        dev_rom_t e;
        case (idx)
            0:       e = '{16'hC8F1, '{'{1'b1, 1'b1, 8'hB0, 8'd0},   '{4'd4, 8'd64,  2'd1, 12'd1024}}};
            1:       e = '{16'hEFAA, '{'{1'b1, 1'b1, 8'hB0, QE_NONE}, '{4'd4, 8'd64,  2'd1, 12'd1024}}};
            2:       e = '{16'h98C2, '{'{1'b0, 1'b0, 8'hB0, QE_NONE}, '{4'd4, 8'd64,  2'd1, 12'd1024}}};
            3:       e = '{16'h2C24, '{'{1'b1, 1'b0, 8'hB0, 8'd3},   '{4'd8, 8'd128, 2'd2, 12'd2048}}};
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic logic [BYTE_W-1:0] bit_mask(input logic [BYTE_W-1:0] idx);
        return 8'h01 << idx[2:0];
    endfunction

endpackage

// File: rtl/nsq_rom.sv
module nsq_rom
    import nsq_pkg::*;
#(
    parameter int ENTRIES = DEV_CNT
) (
    input  logic [ID_W-1:0] id_i,
    output logic            hit_o,
    output dev_cfg_t        cfg_o
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = (dev_rom(g).id == id_i);
    end

    always_comb begin
        cfg_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) cfg_o = dev_rom(i).cfg;
        end
    end

    assign hit_o = |match;
endmodule

// File: rtl/nsq_cfg.sv
module nsq_cfg
    import nsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              geo_ld_i,
    input  geo_t              geo_i,
    input  logic              quad_ld_i,
    input  logic              pg_allow_i,
    output logic [BYTE_W-1:0] rd_opcode_o,
    output logic [BYTE_W-1:0] pg_opcode_o,
    output logic              rd_quad_o,
    output logic              pg_quad_o,
    output geo_t              geo_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            rd_opcode_o <= OP_RD_X1;
            pg_opcode_o <= OP_PG_X1;
            rd_quad_o   <= 1'b0;
            pg_quad_o   <= 1'b0;
            geo_o       <= '0;
        end else begin
            if (geo_ld_i) geo_o <= geo_i;
            if (quad_ld_i) begin
                rd_opcode_o <= OP_RD_X4;
                rd_quad_o   <= 1'b1;
                if (pg_allow_i) begin
                    pg_opcode_o <= OP_PG_X4;
                    pg_quad_o   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/nsq_fsm.sv
module nsq_fsm
    import nsq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmd_ready_i,
    input  logic             rsp_valid_i,
    input  logic             rsp_err_i,
    input  logic [RSP_W-1:0] rsp_rdata_i,
    input  logic             rom_hit_i,
    input  qe_info_t         rom_qe_i,
    output logic             cmd_valid_o,
    output cmd_t             cmd_o,
    output logic             busy_o,
    output logic             done_o,
    output result_e          result_o,
    output logic             cfg_clear_o,
    output logic             geo_ld_o,
    output logic             quad_ld_o,
    output logic             pg_allow_o
);
    typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_e;

    phase_e            phase_q;
    step_e             step_q;
    qe_info_t          dev_q;
    logic [BYTE_W-1:0] qe_val_q;

    logic              rsp_take;
    logic              rsp_ok;
    logic              no_dev;
    logic [BYTE_W-1:0] qe_mask;
    logic              qe_already;

    assign rsp_take   = (phase_q == PH_WAIT) && rsp_valid_i;
    assign rsp_ok     = rsp_take && !rsp_err_i;
    assign no_dev     = (rsp_rdata_i[RSP_W-1 -: BYTE_W] == 8'hFF) ||
                        (rsp_rdata_i[RSP_W-1 -: BYTE_W] == 8'h00);
    assign qe_mask    = bit_mask(dev_q.qe_bit);
    assign qe_already = (rsp_rdata_i[BYTE_W-1:0] & qe_mask) != '0;

    assign busy_o      = (phase_q != PH_IDLE);
    assign cmd_valid_o = (phase_q == PH_ISSUE);
    assign cfg_clear_o = (phase_q == PH_IDLE) && start_i;
    assign geo_ld_o    = rsp_ok && (step_q == STEP_ID) && !no_dev && rom_hit_i;
    assign pg_allow_o  = dev_q.quad_pg;

    always_comb begin
        quad_ld_o = 1'b0;
        if (rsp_ok) begin
            case (step_q)
                STEP_LOCK:  quad_ld_o = dev_q.quad_rd && (dev_q.qe_bit == QE_NONE);
                STEP_QE_RD: quad_ld_o = qe_already;
                STEP_QE_WR: quad_ld_o = 1'b1;
                default:    quad_ld_o = 1'b0;
            endcase
        end
    end

    always_comb begin
        cmd_o = '0;
        case (step_q)
            STEP_ID:    cmd_o = '{OP_READ_ID, 1'b1, 8'h00, 1'b0, 8'h00, 2'd3};
            STEP_LOCK:  cmd_o = '{OP_REG_WR, 1'b1, REG_LOCK, 1'b1, LOCK_OPEN, 2'd0};
            STEP_QE_RD: cmd_o = '{OP_REG_RD, 1'b1, dev_q.qe_addr, 1'b0, 8'h00, 2'd1};
            STEP_QE_WR: cmd_o = '{OP_REG_WR, 1'b1, dev_q.qe_addr, 1'b1, qe_val_q | qe_mask, 2'd0};
            default:    cmd_o = '{OP_WREN, 1'b0, 8'h00, 1'b0, 8'h00, 2'd0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            step_q   <= STEP_ID;
            dev_q    <= '0;
            qe_val_q <= '0;
            done_o   <= 1'b0;
            result_o <= RES_OK;
        end else begin
            done_o <= 1'b0;
            case (phase_q)
                PH_IDLE: if (start_i) begin
                    phase_q <= PH_ISSUE;
                    step_q  <= STEP_ID;
                end
                PH_ISSUE: if (cmd_ready_i) phase_q <= PH_WAIT;
                default: if (rsp_valid_i) begin
                    phase_q <= PH_ISSUE;
                    case (step_q)
                        STEP_ID: begin
                            if (rsp_err_i || no_dev || !rom_hit_i) begin
                                phase_q  <= PH_IDLE;
                                done_o   <= 1'b1;
                                result_o <= rsp_err_i ? RES_BUSERR :
                                            no_dev    ? RES_NODEV  : RES_UNSUP;
                            end else begin
                                dev_q  <= rom_qe_i;
                                step_q <= STEP_WEN_LOCK;
                            end
                        end
                        STEP_WEN_LOCK, STEP_LOCK: begin
                            if (rsp_err_i) begin
                                phase_q  <= PH_IDLE;
                                done_o   <= 1'b1;
                                result_o <= RES_BUSERR;
                            end else if (step_q == STEP_WEN_LOCK) begin
                                step_q <= STEP_LOCK;
                            end else if (!dev_q.quad_rd || dev_q.qe_bit == QE_NONE) begin
                                phase_q  <= PH_IDLE;
                                done_o   <= 1'b1;
                                result_o <= RES_OK;
                            end else begin
                                step_q <= STEP_QE_RD;
                            end
                        end
                        STEP_QE_RD: begin
                            if (rsp_err_i || qe_already) begin
                                phase_q  <= PH_IDLE;
                                done_o   <= 1'b1;
                                result_o <= RES_OK;
                            end else begin
                                qe_val_q <= rsp_rdata_i[BYTE_W-1:0];
                                step_q   <= STEP_WEN_QE;
                            end
                        end
                        STEP_WEN_QE: begin
                            if (rsp_err_i) begin
                                phase_q  <= PH_IDLE;
                                done_o   <= 1'b1;
                                result_o <= RES_OK;
                            end else begin
                                step_q <= STEP_QE_WR;
                            end
                        end
                        default: begin
                            phase_q  <= PH_IDLE;
                            done_o   <= 1'b1;
                            result_o <= RES_OK;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_bringup_seq.sv
module nand_bringup_seq
    import nsq_pkg::*;
#(
    parameter int ENTRIES = DEV_CNT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [1:0]  result_o,
    output logic        cmd_valid_o,
    input  logic        cmd_ready_i,
    output logic [7:0]  cmd_opcode_o,
    output logic        cmd_addr_en_o,
    output logic [7:0]  cmd_addr_o,
    output logic        cmd_wr_en_o,
    output logic [7:0]  cmd_wdata_o,
    output logic [1:0]  cmd_rd_len_o,
    input  logic        rsp_valid_i,
    input  logic        rsp_err_i,
    input  logic [23:0] rsp_rdata_i,
    output logic [7:0]  rd_opcode_o,
    output logic [7:0]  pg_opcode_o,
    output logic        rd_quad_o,
    output logic        pg_quad_o,
    output logic [3:0]  sec_per_page_o,
    output logic [7:0]  pg_per_blk_o,
    output logic [1:0]  planes_o,
    output logic [11:0] blk_per_plane_o
);
    logic     rom_hit;
    dev_cfg_t rom_cfg;
    cmd_t     cmd;
    result_e  result;
    logic     cfg_clear, geo_ld, quad_ld, pg_allow;
    geo_t     geo;

    nsq_rom #(.ENTRIES(ENTRIES)) u_rom (
        .id_i  (rsp_rdata_i[RSP_W-1 -: ID_W]),
        .hit_o (rom_hit),
        .cfg_o (rom_cfg)
    );

    nsq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .cmd_ready_i (cmd_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .rsp_err_i   (rsp_err_i),
        .rsp_rdata_i (rsp_rdata_i),
        .rom_hit_i   (rom_hit),
        .rom_qe_i    (rom_cfg.qe),
        .cmd_valid_o (cmd_valid_o),
        .cmd_o       (cmd),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result),
        .cfg_clear_o (cfg_clear),
        .geo_ld_o    (geo_ld),
        .quad_ld_o   (quad_ld),
        .pg_allow_o  (pg_allow)
    );

    nsq_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (cfg_clear),
        .geo_ld_i    (geo_ld),
        .geo_i       (rom_cfg.geo),
        .quad_ld_i   (quad_ld),
        .pg_allow_i  (pg_allow),
        .rd_opcode_o (rd_opcode_o),
        .pg_opcode_o (pg_opcode_o),
        .rd_quad_o   (rd_quad_o),
        .pg_quad_o   (pg_quad_o),
        .geo_o       (geo)
    );

    assign result_o        = result;
    assign cmd_opcode_o    = cmd.opcode;
    assign cmd_addr_en_o   = cmd.addr_en;
    assign cmd_addr_o      = cmd.addr;
    assign cmd_wr_en_o     = cmd.wr_en;
    assign cmd_wdata_o     = cmd.wdata;
    assign cmd_rd_len_o    = cmd.rd_len;
    assign sec_per_page_o  = geo.sec_per_page;
    assign pg_per_blk_o    = geo.pg_per_blk;
    assign planes_o        = geo.planes;
    assign blk_per_plane_o = geo.blk_per_plane;
endmodule

// File: rtl/nand_bringup_seq_chk.sv
module nand_bringup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy_o,
    input logic       done_o,
    input logic       cmd_valid_o,
    input logic       cmd_ready_i,
    input logic [7:0] cmd_opcode_o,
    input logic [7:0] cmd_addr_o,
    input logic       cmd_wr_en_o,
    input logic [7:0] rd_opcode_o,
    input logic [7:0] pg_opcode_o,
    input logic       rd_quad_o,
    input logic       pg_quad_o
);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R6
    idle_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !cmd_valid_o);

    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_opcode_o) && $stable(cmd_addr_o)));

    // R5
    wdata_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_wr_en_o) |-> (cmd_opcode_o == 8'h1F));

    // R9
    pg_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
        pg_quad_o |-> rd_quad_o);

    // R9
    quad_rd_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        rd_quad_o |-> (rd_opcode_o == 8'h6B));

    // R9
    quad_pg_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        pg_quad_o |-> (pg_opcode_o == 8'h32));
endmodule

bind nand_bringup_seq nand_bringup_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_opcode_o (cmd_opcode_o),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_wr_en_o  (cmd_wr_en_o),
    .rd_opcode_o  (rd_opcode_o),
    .pg_opcode_o  (pg_opcode_o),
    .rd_quad_o    (rd_quad_o),
    .pg_quad_o    (pg_quad_o)
);

// File: tb/nand_bringup_seq_bench.sv
`timescale 1ns/1ps
module nand_bringup_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        busy_o, done_o;
    logic [1:0]  result_o;
    logic        cmd_valid_o;
    logic        cmd_ready_i = 1'b1;
    logic [7:0]  cmd_opcode_o, cmd_addr_o, cmd_wdata_o;
    logic        cmd_addr_en_o, cmd_wr_en_o;
    logic [1:0]  cmd_rd_len_o;
    logic        rsp_valid_i, rsp_err_i;
    logic [23:0] rsp_rdata_i;
    logic [7:0]  rd_opcode_o, pg_opcode_o;
    logic        rd_quad_o, pg_quad_o;
    logic [3:0]  sec_per_page_o;
    logic [7:0]  pg_per_blk_o;
    logic [1:0]  planes_o;
    logic [11:0] blk_per_plane_o;

    always #4 clk = ~clk;

    nand_bringup_seq u_nand_bringup_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_opcode_o(cmd_opcode_o), .cmd_addr_en_o(cmd_addr_en_o), .cmd_addr_o(cmd_addr_o),
        .cmd_wr_en_o(cmd_wr_en_o), .cmd_wdata_o(cmd_wdata_o), .cmd_rd_len_o(cmd_rd_len_o),
        .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i), .rsp_rdata_i(rsp_rdata_i),
        .rd_opcode_o(rd_opcode_o), .pg_opcode_o(pg_opcode_o), .rd_quad_o(rd_quad_o),
        .pg_quad_o(pg_quad_o), .sec_per_page_o(sec_per_page_o), .pg_per_blk_o(pg_per_blk_o),
        .planes_o(planes_o), .blk_per_plane_o(blk_per_plane_o)
    );

    typedef struct packed {
        logic [7:0] id0;
        logic [7:0] id1;
        logic [7:0] b0;
        logic [3:0] err;
        logic [1:0] res;
        logic       qrd;
        logic       qpg;
        logic [3:0] n;
        logic [7:0] b0f;
        logic [7:0] a0f;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'hC8, 8'hF1, 8'h10, 4'hF, 2'd0, 1'b1, 1'b1, 4'd6, 8'h11, 8'h00},
        '{8'hC8, 8'hF1, 8'h11, 4'hF, 2'd0, 1'b1, 1'b1, 4'd4, 8'h11, 8'h00},
        '{8'hEF, 8'hAA, 8'h10, 4'hF, 2'd0, 1'b1, 1'b1, 4'd3, 8'h10, 8'h00},
        '{8'h98, 8'hC2, 8'h10, 4'hF, 2'd0, 1'b0, 1'b0, 4'd3, 8'h10, 8'h00},
        '{8'h2C, 8'h24, 8'h00, 4'hF, 2'd0, 1'b1, 1'b0, 4'd6, 8'h08, 8'h00},
        '{8'hFF, 8'h12, 8'h10, 4'hF, 2'd1, 1'b0, 1'b0, 4'd1, 8'h10, 8'h38},
        '{8'h00, 8'hF1, 8'h10, 4'hF, 2'd1, 1'b0, 1'b0, 4'd1, 8'h10, 8'h38},
        '{8'h12, 8'h34, 8'h10, 4'hF, 2'd2, 1'b0, 1'b0, 4'd1, 8'h10, 8'h38},
        '{8'hC8, 8'hF2, 8'h10, 4'hF, 2'd2, 1'b0, 1'b0, 4'd1, 8'h10, 8'h38},
        '{8'hC8, 8'hF1, 8'h10, 4'h0, 2'd3, 1'b0, 1'b0, 4'd1, 8'h10, 8'h38},
        '{8'hC8, 8'hF1, 8'h10, 4'h1, 2'd3, 1'b0, 1'b0, 4'd2, 8'h10, 8'h38},
        '{8'hC8, 8'hF1, 8'h10, 4'h2, 2'd3, 1'b0, 1'b0, 4'd3, 8'h10, 8'h38},
        '{8'hC8, 8'hF1, 8'h10, 4'h3, 2'd0, 1'b0, 1'b0, 4'd4, 8'h10, 8'h00},
        '{8'hC8, 8'hF1, 8'h10, 4'h4, 2'd0, 1'b0, 1'b0, 4'd5, 8'h10, 8'h00},
        '{8'hC8, 8'hF1, 8'h10, 4'h5, 2'd0, 1'b0, 1'b0, 4'd6, 8'h10, 8'h00}
    };
    localparam string VTAG [NV] = '{"R7", "R7", "R8", "R9", "R9", "R3", "R3", "R4", "R4",
                                    "R6", "R6", "R6", "R10", "R10", "R10"};

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] m_id0, m_id1, m_a0, m_b0;
    logic       m_wel;
    int         err_idx, ncmd, done_cnt;
    logic [7:0] log_op [16];
    logic [7:0] log_addr [16];
    logic [7:0] log_wd [16];
    logic [3:0] log_fl [16];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural command engine with a small device register model
    initial begin
        logic       e;
        logic [23:0] rd;
        rsp_valid_i = 1'b0; rsp_err_i = 1'b0; rsp_rdata_i = '0;
        forever begin
            @(negedge clk);
            rsp_valid_i = 1'b0; rsp_err_i = 1'b0;
            if (!rst && cmd_valid_o && cmd_ready_i) begin
                if (ncmd < 16) begin
                    log_op[ncmd] = cmd_opcode_o; log_addr[ncmd] = cmd_addr_o;
                    log_wd[ncmd] = cmd_wdata_o;
                    log_fl[ncmd] = {cmd_addr_en_o, cmd_wr_en_o, cmd_rd_len_o};
                end
                e = (ncmd == err_idx);
                rd = '0;
                if (!e) begin
                    case (cmd_opcode_o)
                        8'h9F: rd = {m_id0, m_id1, 8'h00};
                        8'h06: m_wel = 1'b1;
                        8'h0F: rd = {16'h0, (cmd_addr_o == 8'hA0) ? m_a0 :
                                            (cmd_addr_o == 8'hB0) ? m_b0 : 8'h00};
                        8'h1F: if (m_wel) begin
                            if (cmd_addr_o == 8'hA0) m_a0 = cmd_wdata_o;
                            else if (cmd_addr_o == 8'hB0) m_b0 = cmd_wdata_o;
                            m_wel = 1'b0;
                        end
                        default: ;
                    endcase
                end
                ncmd++;
                repeat (2) @(negedge clk);
                rsp_valid_i = 1'b1; rsp_err_i = e; rsp_rdata_i = rd;
            end
        end
    end

    initial begin
        done_cnt = 0;
        forever begin
            @(negedge clk);
            if (done_o) done_cnt++;
        end
    end

    task automatic run(input vec_t v, input bit stall);
        m_id0 = v.id0; m_id1 = v.id1; m_a0 = 8'h38; m_b0 = v.b0; m_wel = 1'b0;
        err_idx = int'(v.err); ncmd = 0; done_cnt = 0;
        @(negedge clk);
        cmd_ready_i = !stall;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (stall) begin
            repeat (3) @(negedge clk);
            chk("R2", "id valid held", cmd_valid_o, 1);
            chk("R2", "id opcode", cmd_opcode_o, 8'h9F);
            chk("R2", "id addr_en", cmd_addr_en_o, 1);
            chk("R2", "id addr", cmd_addr_o, 8'h00);
            chk("R2", "id wr_en", cmd_wr_en_o, 0);
            chk("R2", "id rd_len", cmd_rd_len_o, 3);
            chk("R12", "busy in run", busy_o, 1);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            @(posedge clk);
            #1 cmd_ready_i = 1'b1;
        end
        for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            log_op[i] = '0; log_addr[i] = '0; log_wd[i] = '0; log_fl[i] = '0;
        end
        err_idx = 15; ncmd = 0;
        m_id0 = 8'hFF; m_id1 = 8'hFF; m_a0 = 8'h38; m_b0 = 8'h10; m_wel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "cmd_valid", cmd_valid_o, 0);
        chk("R1", "rd opcode", rd_opcode_o, 8'h03);
        chk("R1", "pg opcode", pg_opcode_o, 8'h02);
        chk("R1", "quad lanes", {rd_quad_o, pg_quad_o}, 0);

        for (int k = 0; k < NV; k++) begin
            run(VEC[k], 1'b0);
            chk(VTAG[k], $sformatf("v%0d result", k), result_o, VEC[k].res);
            chk(VTAG[k], $sformatf("v%0d commands", k), ncmd, VEC[k].n);
            chk(VTAG[k], $sformatf("v%0d rd opcode", k), rd_opcode_o, VEC[k].qrd ? 8'h6B : 8'h03);
            chk(VTAG[k], $sformatf("v%0d pg opcode", k), pg_opcode_o, VEC[k].qpg ? 8'h32 : 8'h02);
            chk(VTAG[k], $sformatf("v%0d rd quad", k), rd_quad_o, VEC[k].qrd);
            chk(VTAG[k], $sformatf("v%0d pg quad", k), pg_quad_o, VEC[k].qpg);
            chk(VTAG[k], $sformatf("v%0d qe reg", k), m_b0, VEC[k].b0f);
            chk("R5", $sformatf("v%0d lock reg", k), m_a0, VEC[k].a0f);
            chk("R12", $sformatf("v%0d done pulses", k), done_cnt, 1);
            chk("R12", $sformatf("v%0d idle after", k), {busy_o, done_o}, 0);
        end

        // R2: stalled first command, second start while busy ignored
        run(VEC[0], 1'b1);
        chk("R2", "commands with extra start", ncmd, 6);
        chk("R2", "done pulses with extra start", done_cnt, 1);
        // R5: write-enable then lock clear
        chk("R5", "cmd1 opcode", log_op[1], 8'h06);
        chk("R5", "cmd1 flags", log_fl[1], 4'b0000);
        chk("R5", "cmd2 opcode", log_op[2], 8'h1F);
        chk("R5", "cmd2 addr", log_addr[2], 8'hA0);
        chk("R5", "cmd2 data", log_wd[2], 8'h00);
        chk("R5", "cmd2 flags", log_fl[2], 4'b1100);
        // R7: read-modify-write of the quad-enable register
        chk("R7", "cmd3 opcode", log_op[3], 8'h0F);
        chk("R7", "cmd3 addr", log_addr[3], 8'hB0);
        chk("R7", "cmd3 flags", log_fl[3], 4'b1001);
        chk("R7", "cmd4 opcode", log_op[4], 8'h06);
        chk("R7", "cmd5 opcode", log_op[5], 8'h1F);
        chk("R7", "cmd5 addr", log_addr[5], 8'hB0);
        chk("R7", "cmd5 data", log_wd[5], 8'h11);
        chk("R11", "geo spp a", sec_per_page_o, 4);
        chk("R11", "geo ppb a", pg_per_blk_o, 64);
        chk("R11", "geo planes a", planes_o, 1);
        chk("R11", "geo bpp a", blk_per_plane_o, 1024);

        run(VEC[4], 1'b0);
        chk("R7", "bit3 write data", log_wd[5], 8'h08);
        chk("R11", "geo spp b", sec_per_page_o, 8);
        chk("R11", "geo ppb b", pg_per_blk_o, 128);
        chk("R11", "geo planes b", planes_o, 2);
        chk("R11", "geo bpp b", blk_per_plane_o, 2048);

        run(VEC[7], 1'b0);
        chk("R11", "geo cleared on unsupported", {sec_per_page_o, pg_per_blk_o, planes_o, blk_per_plane_o}, 0);
        chk("R12", "result held", result_o, 2);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule